// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block holds the 16-bit status word of a modem control interface and turns detector events into one interrupt flag and an active-low interrupt pin. Ten event inputs land in status bits 14 down to 5. Bit 15 is the interrupt flag. The flag is set when any of those event bits goes from 0 to 1 while its mask bit in the general control word is 1. The low five status bits always read as zero.

Three things clear the flag: a status-read strobe, a general-reset command strobe, or either the reset bit or the powersave bit of the control word being 1. While reset or powersave is active, every event bit except ring detect is held at zero. Ring detect keeps tracking its input and can still raise the flag. The pin is pulled low only while the flag is 1 and the output-enable bit of the control word is also 1.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word is all zeros and the interrupt pin is high.
- R2: Event input k appears in status bit k+5 one clock after it is sampled. Status bits 4 to 0 are always 0.
- R3: The flag (status bit 15) is 1 in the cycle after a clock edge at which a masked event bit rises from 0 to 1. The mask bit for event k is control bit k when k is 0 to 5, and control bit k+3 when k is 6 to 9.
- R4: An event that is already high when its mask bit is turned on does not set the flag.
- R5: A status-read strobe clears the flag at the next clock edge.
- R6: A general-reset command strobe clears the flag at the next clock edge.
- R7: While control bit 7 (reset) or control bit 8 (powersave) is 1, the flag is cleared and status bits 13 to 5 are held at 0.
- R8: Ring detect (event 9, status bit 14) keeps tracking its input while control bit 7 or 8 is 1. A masked rising edge on it still sets the flag.
- R9: When a set condition and a clear condition occur at the same edge, the flag is set.
- R10: The interrupt pin is low exactly when the flag is 1 and control bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Detector events for status bits 14..5 |
| gcr_i | input | 16 | General control word (masks, enable, reset, powersave) |
| stat_rd_i | input | 1 | Status-read strobe, one cycle |
| gen_rst_i | input | 1 | General-reset command strobe, one cycle |
| status_o | output | 16 | Status word; bit 15 is the interrupt flag |
| irqn_o | output | 1 | Active-low interrupt output |

## Verification
A wrong stored event value has two visible effects, and both appear within one cycle. The status bit reads wrong immediately. A later rising edge is also either missed or invented, which shows as a wrong flag on the following edge. A stuck or wrongly cleared flag shows at once on status bit 15, and on the pin whenever output enable is set. Comparing the status word and the pin against a reference model on every clock therefore catches any state fault no later than the cycle after it forms.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W   = 16;
  localparam int EVT_N    = 10;
  localparam int EVT_LSB  = 5;
  localparam int FLAG_BIT = 15;
  localparam int IEN_BIT  = 6;
  localparam int RST_BIT  = 7;
  localparam int PSV_BIT  = 8;
  localparam int RING_IDX = 9;
  localparam int LOW_MASKS = 6;   // events below this index use control bit = index
  localparam int MASK_SKIP = 3;   // the rest skip control bits 6..8

  function automatic logic [EVT_N-1:0] mask_of(input logic [STAT_W-1:0] gcr);
    logic [EVT_N-1:0] m;
    for (int i = 0; i < EVT_N; i++) begin
      m[i] = (i < LOW_MASKS) ? gcr[i] : gcr[i + MASK_SKIP];
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_evt_track.sv
module irq_evt_track #(
  parameter int N        = 10,
  parameter int KEEP_IDX = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         hold,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] rise
);
  logic [N-1:0] gated;
  logic [N-1:0] stat_d;

  // events other than the kept one are forced low during hold
  for (genvar g = 0; g < N; g++) begin : g_gate
    if (g == KEEP_IDX) begin : g_keep
      assign gated[g] = evt[g];
    end else begin : g_hold
      assign gated[g] = evt[g] & ~hold;
    end
  end

  always_comb begin
    stat_d = gated;
    rise   = gated & ~stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] mask,
  input  logic         clr,
  output logic         set_o,
  output logic         flag_q
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    set_o   = |(rise & mask);
    flag_en = set_o | clr;
    flag_d  = set_o;   // set has priority; otherwise a clear drives 0
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int SW  = STAT_W,
  parameter int EN  = EVT_N,
  parameter int LSB = EVT_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EN-1:0] evt_i,
  input  logic [SW-1:0] gcr_i,
  input  logic          stat_rd_i,
  input  logic          gen_rst_i,
  output logic [SW-1:0] status_o,
  output logic          irqn_o
);
  localparam int PAD = SW - EN - 1;

  logic          rst_q;
  logic          hold;
  logic          clr;
  logic          set_w;
  logic          flag_q;
  logic [EN-1:0] stat_q;
  logic [EN-1:0] rise;
  logic [EN-1:0] mask;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  always_comb begin
    hold = gcr_i[RST_BIT] | gcr_i[PSV_BIT];
    clr  = stat_rd_i | gen_rst_i | hold;
    mask = mask_of(gcr_i);
  end

  irq_evt_track #(.N(EN), .KEEP_IDX(RING_IDX)) u_evt (
    .clk    (clk),
    .rst_n  (rst_q),
    .evt    (evt_i),
    .hold   (hold),
    .stat_q (stat_q),
    .rise   (rise)
  );

  irq_flag_ctrl #(.N(EN)) u_flag (
    .clk    (clk),
    .rst_n  (rst_q),
    .rise   (rise),
    .mask   (mask),
    .clr    (clr),
    .set_o  (set_w),
    .flag_q (flag_q)
  );

  assign status_o = {flag_q, stat_q, {PAD{1'b0}}};
  assign irqn_o   = ~(flag_q & gcr_i[IEN_BIT]);
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
  input logic        clk,
  input logic        rst_q,
  input logic [9:0]  evt_i,
  input logic [15:0] gcr_i,
  input logic        stat_rd_i,
  input logic        gen_rst_i,
  input logic        set_w,
  input logic [15:0] status_o,
  input logic        irqn_o
);
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_q)
    status_o[4:0] == 5'b0);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_q)
    (stat_rd_i && !set_w) |=> !status_o[15]);

  a_r6_cmd_clears: assert property (@(posedge clk) disable iff (!rst_q)
    (gen_rst_i && !set_w) |=> !status_o[15]);

  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (gcr_i[7] || gcr_i[8]) |=> (status_o[13:5] == 9'b0));

  a_r8_ring_tracks: assert property (@(posedge clk) disable iff (!rst_q)
    (gcr_i[7] || gcr_i[8]) |=> (status_o[14] == $past(evt_i[9])));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_q)
    set_w |=> status_o[15]);

  a_r10_pin: assert property (@(posedge clk) disable iff (!rst_q)
    (!status_o[15] || !gcr_i[6]) |-> irqn_o);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .evt_i     (evt_i),
  .gcr_i     (gcr_i),
  .stat_rd_i (stat_rd_i),
  .gen_rst_i (gen_rst_i),
  .set_w     (set_w),
  .status_o  (status_o),
  .irqn_o    (irqn_o)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_i = '0;
  logic [15:0] gcr_i = '0;
  logic        stat_rd_i = 1'b0;
  logic        gen_rst_i = 1'b0;
  logic [15:0] status_o;
  logic        irqn_o;

  int checks = 0;
  int errors = 0;
  int rcnt = 0;
  logic [9:0] m_ev = '0;
  logic       m_flag = 1'b0;
  bit         done = 0;

  always #2 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .gcr_i(gcr_i),
    .stat_rd_i(stat_rd_i), .gen_rst_i(gen_rst_i),
    .status_o(status_o), .irqn_o(irqn_o)
  );

  // behavioural reference, one update per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; m_ev = '0; m_flag = 1'b0;
    end else if (rcnt < 2) begin
      rcnt = rcnt + 1; m_ev = '0; m_flag = 1'b0;
    end else begin
      bit hold, setc, clrc, g;
      int mb;
      hold = gcr_i[7] || gcr_i[8];
      setc = 0;
      for (int i = 0; i < 10; i++) begin
        g  = evt_i[i] && (i == 9 || !hold);
        mb = (i < 6) ? i : i + 3;
        if (g && !m_ev[i] && gcr_i[mb]) setc = 1;
        m_ev[i] = g;
      end
      clrc = stat_rd_i || gen_rst_i || hold;
      if (setc) m_flag = 1'b1;
      else if (clrc) m_flag = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && rcnt >= 2 && !done) begin
      chk("R2 event bits", {22'b0, status_o[14:5]}, {22'b0, m_ev});
      chk("R2 low bits", {27'b0, status_o[4:0]}, 32'b0);
      chk("R3 flag", {31'b0, status_o[15]}, {31'b0, m_flag});
      chk("R10 pin", {31'b0, irqn_o}, {31'b0, !(m_flag && gcr_i[6])});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        #1;
        cyc(3);
        rst_n = 1'b1;
        cyc(4);
        // R1 reset state
        chk("R1 status", {16'b0, status_o}, 32'h0);
        chk("R1 pin", {31'b0, irqn_o}, 32'h1);

        // R3 and R10: all masks on, output enable on
        gcr_i = 16'h1E3F | 16'h0040;
        evt_i[0] = 1'b1; cyc(1);
        chk("R3 set on masked edge", {31'b0, status_o[15]}, 32'h1);
        chk("R2 bit5 follows", {31'b0, status_o[5]}, 32'h1);
        chk("R10 pin low", {31'b0, irqn_o}, 32'h0);

        // R5 status read clears, held event does not re-set
        stat_rd_i = 1'b1; cyc(1); stat_rd_i = 1'b0;
        chk("R5 read clears", {31'b0, status_o[15]}, 32'h0);
        cyc(2);
        chk("R5 stays clear", {31'b0, status_o[15]}, 32'h0);

        // R10 pin gated by enable
        gcr_i[6] = 1'b0;
        evt_i[3] = 1'b1; cyc(1);
        chk("R10 flag set", {31'b0, status_o[15]}, 32'h1);
        chk("R10 pin high when disabled", {31'b0, irqn_o}, 32'h1);
        gcr_i[6] = 1'b1; #1;
        chk("R10 pin low when enabled", {31'b0, irqn_o}, 32'h0);

        // R6 general reset command clears
        gen_rst_i = 1'b1; cyc(1); gen_rst_i = 1'b0;
        chk("R6 command clears", {31'b0, status_o[15]}, 32'h0);

        // R4 already-high event, mask enabled later (event 5 -> control bit 5)
        gcr_i[5] = 1'b0;
        evt_i[5] = 1'b1; cyc(1);
        chk("R4 unmasked edge no flag", {31'b0, status_o[15]}, 32'h0);
        chk("R2 unmasked bit visible", {31'b0, status_o[10]}, 32'h1);
        gcr_i[5] = 1'b1; cyc(2);
        chk("R4 level does not set", {31'b0, status_o[15]}, 32'h0);

        // event 7 uses control bit 10
        gcr_i[10] = 1'b0; evt_i[7] = 1'b1; cyc(1);
        chk("R3 mask bit 10 off", {31'b0, status_o[15]}, 32'h0);
        evt_i[7] = 1'b0; gcr_i[10] = 1'b1; cyc(1);
        evt_i[7] = 1'b1; cyc(1);
        chk("R3 mask bit 10 on", {31'b0, status_o[15]}, 32'h1);

        // R7 reset bit clears flag and holds non-ring bits
        gcr_i[7] = 1'b1; cyc(1);
        chk("R7 flag cleared", {31'b0, status_o[15]}, 32'h0);
        chk("R7 bits held", {23'b0, status_o[13:5]}, 32'h0);
        gcr_i[7] = 1'b0; evt_i = '0; cyc(2);

        // R8 ring under powersave (ring mask = control bit 12)
        gcr_i[8] = 1'b1; evt_i[9] = 1'b1; evt_i[1] = 1'b1; cyc(1);
        chk("R8 ring tracks", {31'b0, status_o[14]}, 32'h1);
        chk("R8 ring sets flag", {31'b0, status_o[15]}, 32'h1);
        chk("R7 other held", {31'b0, status_o[6]}, 32'h0);
        cyc(1);
        chk("R7 hold clears flag", {31'b0, status_o[15]}, 32'h0);
        gcr_i[8] = 1'b0; evt_i = '0; cyc(2);

        // R9 set beats read in the same cycle
        evt_i[2] = 1'b1; stat_rd_i = 1'b1; cyc(1); stat_rd_i = 1'b0;
        chk("R9 set wins", {31'b0, status_o[15]}, 32'h1);
        evt_i[4] = 1'b1; gen_rst_i = 1'b1; cyc(1); gen_rst_i = 1'b0;
        chk("R9 set wins over command", {31'b0, status_o[15]}, 32'h1);

        // mixed pattern run
        for (int k = 0; k < 200; k++) begin
          evt_i     = 10'((k * 37) ^ (k >> 2));
          stat_rd_i = (k % 7) == 0;
          gen_rst_i = (k % 11) == 0;
          gcr_i     = 16'((k * 91) ^ 16'h1E7F) & ~16'h0180;
          if (k % 13 == 0) gcr_i[7] = 1'b1;
          if (k % 17 == 0) gcr_i[8] = 1'b1;
          cyc(1);
        end
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule